// File: doc/BRIEF.md
# Redundant-Arithmetic CORDIC Micro-Rotation Stage

This block performs one micro-rotation of order `ORDER` on a vector whose X and Y coordinates are each held as a pair of vectors: a sum and a carry. The real value of a coordinate is the modular sum of its pair. A direction bit, worked out ahead of time, picks the sense of rotation. The stage never resolves a carry chain. Each lane shifts the other coordinate's sum and carry vectors right by `ORDER`, with sign fill. When the lane subtracts, it inverts those shifted bits. It then reduces its four operands with a single row of 4-2 compressors, and the rotated coordinate comes out again as a sum/carry pair.

The constant that completes the two's-complement subtraction goes into the free LSB slots of the compressor row: the carry-in of column 0 and bit 0 of the carry output. Setting `ROUND_BIAS` selects the rounding variant. In that variant the total constant is one LSB in both directions, which offsets the truncation of the shifted-out bits. The result is registered on `in_valid`. A chain of these stages sits between a wiring-only conversion stage and final merging adders.

Top module: `cs_cordic_stage`

## Requirements
- R1: The output value of a coordinate is the sum of its output sum and carry vectors modulo 2^W. With ROUND_BIAS=0 and dir_i=1, x = xs+xc - (ys>>>ORDER) - (yc>>>ORDER), where >>> is an arithmetic shift of each W-bit vector on its own.
- R2: With ROUND_BIAS=0 and dir_i=1, y = ys+yc + (xs>>>ORDER) + (xc>>>ORDER).
- R3: With ROUND_BIAS=0 and dir_i=0, the signs swap: x = xs+xc + (ys>>>ORDER)+(yc>>>ORDER) and y = ys+yc - (xs>>>ORDER) - (xc>>>ORDER).
- R4: The shift fills with the sign bit of each vector separately, so a negative sum or carry vector contributes the floor of its value divided by 2^ORDER.
- R5: All results wrap modulo 2^W. Nothing flags an overflow.
- R6: With ROUND_BIAS=1, a lane that adds yields self + t_s + t_c + 1, and a lane that subtracts yields self + ~t_s + ~t_c + 1. Here t_s and t_c are the shifted operand vectors.
- R7: Outputs are registered. Data presented with in_valid=1 appears on the next rising edge, and out_valid is in_valid delayed by one cycle.
- R8: While in_valid=0, the data outputs keep their values whatever the data inputs do.
- R9: An active-low rst_n clears out_valid and all output vectors at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture enable for the input vector |
| dir_i | input | 1 | 1: x -= y/2^i, y += x/2^i; 0: opposite |
| x_sum_i | input | W | X coordinate, sum vector |
| x_car_i | input | W | X coordinate, carry vector |
| y_sum_i | input | W | Y coordinate, sum vector |
| y_car_i | input | W | Y coordinate, carry vector |
| out_valid | output | 1 | Output vector valid |
| x_sum_o | output | W | Rotated X, sum vector |
| x_car_o | output | W | Rotated X, carry vector |
| y_sum_o | output | W | Rotated Y, sum vector |
| y_car_o | output | W | Rotated Y, carry vector |

## Verification
The rotation is tried in both directions with small positive values, with negative carry vectors, and with sum and carry vectors of opposite sign. That last pattern separates shifting each vector on its own from shifting their merged sum. Patterns whose low ORDER bits are nonzero in both vectors expose any truncation that differs from a per-vector floor. Patterns near the most positive and most negative codes show that the result wraps instead of saturating. Running the same vectors through a second instance with the rounding bias shows how the LSB constant depends on direction.

// File: rtl/cs_cordic_pkg.sv
`timescale 1ns/1ps
package cs_cordic_pkg;
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/cs_compress42_row.sv
`timescale 1ns/1ps
module cs_compress42_row
  import cs_cordic_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  input  logic         k_lo_i,
  input  logic         k_hi_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] car_o
);
  logic [W:0]   chain;
  logic [W-1:0] s1;
  logic [W-1:0] c2;

  assign chain[0] = k_lo_i;

  for (genvar j = 0; j < W; j++) begin : g_col
    assign s1[j]      = a_i[j] ^ b_i[j] ^ c_i[j];
    assign chain[j+1] = maj3(a_i[j], b_i[j], c_i[j]);
    assign sum_o[j]   = s1[j] ^ d_i[j] ^ chain[j];
    assign c2[j]      = maj3(s1[j], d_i[j], chain[j]);
  end

  assign car_o = {c2[W-2:0], k_hi_i};

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i, d_i, k_lo_i, k_hi_i}))
      assert_row_sum_R1: assert (W'(sum_o + car_o) ==
        W'(a_i + b_i + c_i + d_i + W'(k_lo_i) + W'(k_hi_i)))
        else $error("compressor row lost value");
  end
endmodule

// File: rtl/cs_lane.sv
`timescale 1ns/1ps
module cs_lane #(
  parameter int W          = 16,
  parameter int ORDER      = 3,
  parameter bit ROUND_BIAS = 1'b0
) (
  input  logic [W-1:0] self_s_i,
  input  logic [W-1:0] self_c_i,
  input  logic [W-1:0] oth_s_i,
  input  logic [W-1:0] oth_c_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] car_o
);
  logic [W-1:0] sh_s, sh_c, op_s, op_c;
  logic         k_lo, k_hi;

  assign sh_s = W'($signed(oth_s_i) >>> ORDER);
  assign sh_c = W'($signed(oth_c_i) >>> ORDER);
  assign op_s = sh_s ^ {W{sub_i}};
  assign op_c = sh_c ^ {W{sub_i}};

  if (ROUND_BIAS) begin : g_bias
    assign k_lo = 1'b1;
    assign k_hi = 1'b0;
  end else begin : g_exact
    assign k_lo = sub_i;
    assign k_hi = sub_i;
  end

  cs_compress42_row #(.W(W)) u_row (
    .a_i(self_s_i), .b_i(self_c_i), .c_i(op_s), .d_i(op_c),
    .k_lo_i(k_lo), .k_hi_i(k_hi), .sum_o(sum_o), .car_o(car_o)
  );
endmodule

// File: rtl/cs_cordic_stage.sv
`timescale 1ns/1ps
module cs_cordic_stage #(
  parameter int W          = 16,
  parameter int ORDER      = 3,
  parameter bit ROUND_BIAS = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         dir_i,
  input  logic [W-1:0] x_sum_i,
  input  logic [W-1:0] x_car_i,
  input  logic [W-1:0] y_sum_i,
  input  logic [W-1:0] y_car_i,
  output logic         out_valid,
  output logic [W-1:0] x_sum_o,
  output logic [W-1:0] x_car_o,
  output logic [W-1:0] y_sum_o,
  output logic [W-1:0] y_car_o
);
  localparam int SHIFT_OK = (ORDER < W) ? 1 : 0;

  logic [W-1:0] xs_n, xc_n, ys_n, yc_n;
  logic [W-1:0] xs_d, xc_d, ys_d, yc_d;
  logic         vld_d;

  initial begin
    assert_shift_fits_R4: assert (SHIFT_OK == 1) else $error("ORDER too large");
  end

  cs_lane #(.W(W), .ORDER(ORDER), .ROUND_BIAS(ROUND_BIAS)) u_xlane (
    .self_s_i(x_sum_i), .self_c_i(x_car_i), .oth_s_i(y_sum_i), .oth_c_i(y_car_i),
    .sub_i(dir_i), .sum_o(xs_n), .car_o(xc_n)
  );

  cs_lane #(.W(W), .ORDER(ORDER), .ROUND_BIAS(ROUND_BIAS)) u_ylane (
    .self_s_i(y_sum_i), .self_c_i(y_car_i), .oth_s_i(x_sum_i), .oth_c_i(x_car_i),
    .sub_i(!dir_i), .sum_o(ys_n), .car_o(yc_n)
  );

  always_comb begin
    vld_d = in_valid;
    xs_d  = x_sum_o;
    xc_d  = x_car_o;
    ys_d  = y_sum_o;
    yc_d  = y_car_o;
    if (in_valid) begin
      xs_d = xs_n;
      xc_d = xc_n;
      ys_d = ys_n;
      yc_d = yc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      x_sum_o   <= '0;
      x_car_o   <= '0;
      y_sum_o   <= '0;
      y_car_o   <= '0;
    end else begin
      out_valid <= vld_d;
      x_sum_o   <= xs_d;
      x_car_o   <= xc_d;
      y_sum_o   <= ys_d;
      y_car_o   <= yc_d;
    end
  end

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("out_valid missing");

  assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid) else $error("out_valid spurious");

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(x_sum_o) && $stable(x_car_o) &&
                   $stable(y_sum_o) && $stable(y_car_o)))
    else $error("outputs moved while idle");

  always @(posedge clk) begin
    if (!rst_n)
      assert_reset_clear_R9: assert (!out_valid && x_sum_o == '0 && x_car_o == '0 &&
                                     y_sum_o == '0 && y_car_o == '0)
        else $error("reset did not clear");
  end
endmodule

// File: tb/cs_cordic_stage_test.sv
`timescale 1ns/1ps
module cs_cordic_stage_test;
  localparam int W = 16;
  localparam int ORDER = 3;
  localparam int NV = 8;

  // {x_sum, x_car, y_sum, y_car, dir}
  localparam logic [4*W:0] VEC [NV] = '{
    {16'h0100, 16'h0000, 16'h0080, 16'h0000, 1'b1},
    {16'h0100, 16'h0000, 16'h0080, 16'h0000, 1'b0},
    {16'h0123, 16'hFF07, 16'hFFF9, 16'h000F, 1'b1},
    {16'h7FF0, 16'h0008, 16'h7FFF, 16'h7FFF, 1'b0},
    {16'h8000, 16'h8001, 16'h8000, 16'h0007, 1'b1},
    {16'hFFFF, 16'hFFFF, 16'h0007, 16'hFFF9, 1'b0},
    {16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 1'b1},
    {16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic in_valid = 1'b0, dir = 1'b0;
  logic [W-1:0] xs = '0, xc = '0, ys = '0, yc = '0;
  logic         v0, v1;
  logic [W-1:0] axs, axc, ays, ayc, bxs, bxc, bys, byc;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  cs_cordic_stage #(.W(W), .ORDER(ORDER), .ROUND_BIAS(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir_i(dir),
    .x_sum_i(xs), .x_car_i(xc), .y_sum_i(ys), .y_car_i(yc),
    .out_valid(v0), .x_sum_o(axs), .x_car_o(axc), .y_sum_o(ays), .y_car_o(ayc));

  cs_cordic_stage #(.W(W), .ORDER(ORDER), .ROUND_BIAS(1'b1)) uut_rb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir_i(dir),
    .x_sum_i(xs), .x_car_i(xc), .y_sum_i(ys), .y_car_i(yc),
    .out_valid(v1), .x_sum_o(bxs), .x_car_o(bxc), .y_sum_o(bys), .y_car_o(byc));

  function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic [W-1:0] c,
                                         input logic [W-1:0] os, input logic [W-1:0] oc,
                                         input logic sub, input logic bias);
    logic [W-1:0] ts, tc;
    ts = W'($signed(os) >>> ORDER);
    tc = W'($signed(oc) >>> ORDER);
    if (sub) return W'(s + c + ~ts + ~tc + (bias ? 16'd1 : 16'd2));
    else     return W'(s + c + ts + tc + (bias ? 16'd1 : 16'd0));
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4*W:0] v);
    @(negedge clk);
    {xs, xc, ys, yc, dir} = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  logic [W-1:0] hold_x, hold_y;

  initial begin
    #1 rst_n = 1'b0;
    #10;
    check("R9 reset valid", {15'd0, v0}, 16'd0);
    check("R9 reset x", W'(axs + axc), 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [W-1:0] exs, exc, eys, eyc;
      logic         ed;
      {exs, exc, eys, eyc, ed} = VEC[k];
      drive(VEC[k]);
      // R1 R2 R3 R4 R5: exact lanes; R6: biased lanes
      check(ed ? "R1 x lane" : "R3 x lane", W'(axs + axc), model(exs, exc, eys, eyc, ed, 1'b0));
      check(ed ? "R2 y lane" : "R3 y lane", W'(ays + ayc), model(eys, eyc, exs, exc, !ed, 1'b0));
      check("R6 x lane bias", W'(bxs + bxc), model(exs, exc, eys, eyc, ed, 1'b1));
      check("R6 y lane bias", W'(bys + byc), model(eys, eyc, exs, exc, !ed, 1'b1));
      check("R7 valid", {15'd0, v0}, 16'd1);
    end

    // R4: separate per-vector floor differs from merged shift here
    drive({16'h0000, 16'h0000, 16'h0007, 16'h0001, 1'b0});
    check("R4 per-vector floor", W'(axs + axc), 16'h0000);

    // R5: wrap past most positive code
    drive({16'h7FFF, 16'h0000, 16'h0008, 16'h0000, 1'b0});
    check("R5 wrap", W'(axs + axc), 16'h8000);

    // R7: valid drops one cycle after in_valid low
    @(negedge clk);
    check("R7 valid low", {15'd0, v0}, 16'd0);

    // R8: inputs change while idle
    hold_x = W'(axs + axc);
    hold_y = W'(ays + ayc);
    xs = 16'h5555; ys = 16'hAAAA; dir = ~dir;
    @(negedge clk);
    @(negedge clk);
    check("R8 hold x", W'(axs + axc), hold_x);
    check("R8 hold y", W'(ays + ayc), hold_y);

    // R9: asynchronous clear mid-cycle
    #0.5 rst_n = 1'b0;
    #0.5;
    check("R9 async clear", axs | axc | ays | ayc, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    tests++;
    fails++;
    $display("FAIL R7 watchdog expired: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule